// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block looks after one external interrupt request pin. Software configures it through a single 8-bit status/control register on a simple synchronous register bus, which has a select, a write strobe, an address and read data. The pin passes through a two-flop synchronizer. An edge detector then recognises transitions into the asserted level of the programmed polarity. A mode bit can extend detection to cover a held asserted level as well as the edge.

A detected event sets a sticky flag. Software clears the flag by writing 1 to a self-clearing acknowledge bit. When the interrupt enable is set, the flag drives an interrupt request towards the CPU. Otherwise software polls the flag. The block also produces pull-up and pull-down enables for the pad. The pull direction follows the chosen polarity, and a disable bit can turn both pulls off.

Top module: `extint_ctrl`

## Requirements
- R1: All register bits reset to 0. The register reads as {bit7=0, bit6 pull-off, bit5 rising-polarity, bit4 pin-enable, bit3 flag, bit2=0, bit1 irq-enable, bit0 level-mode}.
- R2: The pin is sampled through two flops. A pin change driven between clock edges sets the flag on the third rising clock edge after the change, and not before.
- R3: With bit0=0 (edge mode), only a transition into the asserted level sets the flag. Holding the pin asserted after an acknowledge leaves the flag clear.
- R4: With bit5=0, falling edges and low levels are detected. With bit5=1, rising edges and high levels are detected.
- R5: With bit0=1 (level mode), the flag is set on every clock in which the pin is asserted. An acknowledge written while the pin stays asserted leaves the flag at 1.
- R6: Writing 1 to bit2 clears the flag. Writing 0 to bit2 leaves the flag unchanged. Bit2 and bit7 always read 0.
- R7: irq_req is 1 exactly when the flag is 1 and bit1 is 1.
- R8: With bit4=1 and bit6=0, pull_dn_en=1 when bit5=1 and pull_up_en=1 when bit5=0. With bit6=1, both pulls are 0.
- R9: With bit4=0, pin activity never sets the flag, both pulls are 0, and an already-set flag holds.
- R10: An acknowledge and a new qualifying event in the same clock leave the flag set.
- R11: While the pin function is disabled, the detector history holds the deasserted level. Enabling the pin while it is already asserted therefore counts as one event.
- R12: Reads return 0 unless bus_sel=1 and bus_addr equals REG_ADDR. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (1 = write) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 1 | Raw external interrupt pin |
| irq_req | output | 1 | Interrupt request to the CPU |
| pull_up_en | output | 1 | Pad pull-up enable |
| pull_dn_en | output | 1 | Pad pull-down enable |

## Verification
Directed sequences drive the pin with single rising and falling edges in both polarities. They tell correct polarity apart from inverted polarity, and they measure the exact three-clock latency. Held asserted levels combined with acknowledges separate edge mode from level mode. An acknowledge placed in the same clock as a fresh edge shows which of the two has priority. Enabling the pin while it is already asserted exposes how the history is initialised. A long constrained-random run then mixes pin toggles with reads and writes at matching and foreign addresses, and a cycle-level model checks every output on every clock.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int REG_W    = 8;
   localparam int B_PULLOFF = 6;
   localparam int B_POL     = 5;
   localparam int B_PINEN   = 4;
   localparam int B_FLAG    = 3;
   localparam int B_ACK     = 2;
   localparam int B_IRQEN   = 1;
   localparam int B_LVL     = 0;

   typedef struct packed {
      logic pull_off;
      logic pol_rise;
      logic pin_en;
      logic irq_en;
      logic lvl_mode;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{default: 1'b0};
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("extint_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RST_VAL;
               else        chain_q[gi] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RST_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_sync,
   input  logic pin_en,
   input  logic pol_rise,
   input  logic lvl_mode,
   output logic asserted,
   output logic evt
);
   logic hist_q;
   logic edge_hit;
   logic lvl_hit;

   // normalise to "1 = asserted" for the selected polarity
   assign asserted = pol_rise ? pin_sync : ~pin_sync;

   // history holds deasserted level while disabled (no stale edge memory)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_q <= 1'b0;
      else if (!pin_en) hist_q <= 1'b0;
      else              hist_q <= asserted;
   end

   assign edge_hit = pin_en & asserted & ~hist_q;
   assign lvl_hit  = pin_en & lvl_mode & asserted;
   assign evt      = edge_hit | lvl_hit;

   AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!pin_en) && pin_en && asserted |-> evt); // R11
endmodule

// File: rtl/extint_regs.sv
module extint_regs
   import extint_pkg::*;
#(
   parameter int          ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              evt,
   output ctrl_t             ctrl,
   output logic              flag,
   output logic [REG_W-1:0]  bus_rdata
);
   logic  hit;
   logic  wr_hit;
   logic  ack_hit;
   ctrl_t ctrl_q;
   logic  flag_q;

   assign hit     = bus_sel && (bus_addr == REG_ADDR);
   assign wr_hit  = hit && bus_wr;
   assign ack_hit = wr_hit && bus_wdata[B_ACK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (wr_hit) begin
         ctrl_q.pull_off <= bus_wdata[B_PULLOFF];
         ctrl_q.pol_rise <= bus_wdata[B_POL];
         ctrl_q.pin_en   <= bus_wdata[B_PINEN];
         ctrl_q.irq_en   <= bus_wdata[B_IRQEN];
         ctrl_q.lvl_mode <= bus_wdata[B_LVL];
      end
   end

   // event has priority over acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (evt)     flag_q <= 1'b1;
      else if (ack_hit) flag_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[B_PULLOFF] = ctrl_q.pull_off;
         bus_rdata[B_POL]     = ctrl_q.pol_rise;
         bus_rdata[B_PINEN]   = ctrl_q.pin_en;
         bus_rdata[B_FLAG]    = flag_q;
         bus_rdata[B_IRQEN]   = ctrl_q.irq_en;
         bus_rdata[B_LVL]     = ctrl_q.lvl_mode;
      end
   end

   assign ctrl = ctrl_q;
   assign flag = flag_q;

   AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(ack_hit)); // R6
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt) |-> flag_q); // R10
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
   import extint_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              pin_in,
   output logic              irq_req,
   output logic              pull_up_en,
   output logic              pull_dn_en
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("extint_ctrl: ADDR_W must be positive");
      end
      if (REG_W != 8) begin : g_bad_width
         $error("extint_ctrl: register width must be 8");
      end
   endgenerate

   ctrl_t ctrl;
   logic  flag;
   logic  pin_sync;
   logic  asserted;
   logic  evt;
   logic  pull_on;

   extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_sync)
   );

   extint_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync),
      .pin_en   (ctrl.pin_en),
      .pol_rise (ctrl.pol_rise),
      .lvl_mode (ctrl.lvl_mode),
      .asserted (asserted),
      .evt      (evt)
   );

   extint_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .evt       (evt),
      .ctrl      (ctrl),
      .flag      (flag),
      .bus_rdata (bus_rdata)
   );

   assign irq_req    = flag & ctrl.irq_en;
   assign pull_on    = ctrl.pin_en & ~ctrl.pull_off;
   assign pull_up_en = pull_on & ~ctrl.pol_rise;
   assign pull_dn_en = pull_on &  ctrl.pol_rise;

   AST_RISE_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ctrl.pin_en)); // R9
   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl.pin_en && ctrl.lvl_mode && asserted) |-> flag); // R5
   AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pull_up_en, pull_dn_en})); // R8
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, wr = 1'b0, pin = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, pu, pd;
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   extint_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin), .irq_req(irq),
      .pull_up_en(pu), .pull_dn_en(pd)
   );

   // cycle-level reference model built from the requirements
   logic m_s1, m_s2, m_hist, m_flag, m_pdd, m_pol, m_pe, m_ie, m_lvl;

   function automatic logic f_act(logic s, logic pol);
      return pol ? s : ~s;
   endfunction
   function automatic logic f_evt(logic pe, logic act, logic hist, logic lvl);
      return pe & act & (~hist | lvl);
   endfunction
   function automatic logic [7:0] f_read(logic s, logic [3:0] a);
      if (!(s && a == 4'd0)) return 8'h00;
      return {1'b0, m_pdd, m_pol, m_pe, m_flag, 1'b0, m_ie, m_lvl};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_s1, m_s2, m_hist, m_flag, m_pdd, m_pol, m_pe, m_ie, m_lvl} <= '0;
      end else begin
         logic act, ev, wh;
         act = f_act(m_s2, m_pol);
         ev  = f_evt(m_pe, act, m_hist, m_lvl);
         wh  = sel && wr && addr == 4'd0;
         m_s1   <= pin;
         m_s2   <= m_s1;
         m_hist <= m_pe ? act : 1'b0;
         m_flag <= ev ? 1'b1 : (wh && wdata[2]) ? 1'b0 : m_flag;
         if (wh) {m_pdd, m_pol, m_pe, m_ie, m_lvl} <=
                 {wdata[6], wdata[5], wdata[4], wdata[1], wdata[0]};
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // every clock: outputs against the model, sampled 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R7", {7'd0, irq}, {7'd0, m_flag & m_ie});
         chk("R8", {6'd0, pu, pd},
             {6'd0, m_pe & ~m_pdd & ~m_pol, m_pe & ~m_pdd & m_pol});
         chk("R12", rdata, f_read(sel, addr));
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask
   task automatic wreg(logic [7:0] d, logic [3:0] a = 4'd0);
      sel = 1; wr = 1; addr = a; wdata = d;
      tick();
      sel = 0; wr = 0; wdata = '0; addr = '0;
   endtask
   task automatic rreg(output logic [7:0] d, input logic [3:0] a = 4'd0);
      sel = 1; wr = 0; addr = a;
      #0.5 d = rdata;
      tick();
      sel = 0;
   endtask

   initial begin
      logic [7:0] r;
      tick(3);
      rreg(r);
      chk("R1 reset", r, 8'h00);
      chk("R1 reset outs", {5'd0, irq, pu, pd}, 8'h00);
      rst_n = 1;
      tick(2);

      // rising, edge mode, irq on
      wreg(8'h32);
      rreg(r);
      chk("R1 readback", r, 8'h32);
      chk("R8 rising pull", {6'd0, pu, pd}, 8'h01);
      pin = 1;
      tick(2);
      chk("R2 not yet", {7'd0, irq}, 8'h00);
      tick();
      chk("R2 third edge", {7'd0, irq}, 8'h01);
      wreg(8'h32);
      rreg(r);
      chk("R6 ack0 keeps", r, 8'h3A);
      wreg(8'h36);
      tick(3);
      rreg(r);
      chk("R3 held no reset", r, 8'h32);

      // level mode with pin held high
      wreg(8'h33);
      tick(2);
      chk("R5 level sets", {7'd0, irq}, 8'h01);
      wreg(8'h37);
      rreg(r);
      chk("R5 ack blocked", r, 8'h3B);
      chk("R6 bit2 reads 0", {7'd0, r[2]}, 8'h00);
      pin = 0;
      tick(4);
      wreg(8'h37);
      rreg(r);
      chk("R5 cleared when low", r, 8'h33);

      // falling polarity, pull-up
      wreg(8'h12);
      chk("R8 falling pull", {6'd0, pu, pd}, 8'h02);
      tick(3);
      wreg(8'h16);
      pin = 1;
      tick(4);
      chk("R4 rise ignored", {7'd0, irq}, 8'h00);
      pin = 0;
      tick(3);
      chk("R4 fall detected", {7'd0, irq}, 8'h01);
      wreg(8'h52);
      chk("R8 pull off", {6'd0, pu, pd}, 8'h00);

      // disabled: flag holds, no events
      wreg(8'h02);
      chk("R9 pulls off", {6'd0, pu, pd}, 8'h00);
      chk("R9 flag holds", {7'd0, irq}, 8'h01);
      wreg(8'h06);
      pin = 1; tick(4); pin = 0; tick(4);
      chk("R9 no events", {7'd0, irq}, 8'h00);

      // enable while already asserted
      pin = 1;
      tick(4);
      wreg(8'h32);
      tick();
      chk("R11 enable asserted", {7'd0, irq}, 8'h01);

      // ack in the same clock as a new edge
      pin = 0;
      tick(4);
      rreg(r);
      chk("R10 setup flag", {7'd0, r[3]}, 8'h01);
      pin = 1;
      tick(2);
      wreg(8'h36);
      chk("R10 event wins", {7'd0, irq}, 8'h01);

      // foreign address
      wreg(8'h00, 4'd5);
      rreg(r);
      chk("R12 foreign write", r, 8'h3A);
      rreg(r, 4'd3);
      chk("R12 foreign read", r, 8'h00);

      // constrained random against the model
      void'($urandom(32'h5EED));
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(3) == 0) pin = ~pin;
         if ($urandom_range(2) == 0) begin
            sel = 1; wr = $urandom_range(1);
            addr = ($urandom_range(4) == 0) ? 4'($urandom_range(15)) : 4'd0;
            wdata = 8'($urandom);
         end else begin
            sel = 0; wr = 0;
         end
         tick();
      end
      sel = 0; wr = 0;
      tick(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule